// File: doc/BRIEF.md
# Bus-side launcher and reader for a blank/convert converter

This block sits between an 8-bit processor bus and a successive-approximation converter controlled by a single blank/convert line and an active-low data-ready line. A write strobe to the start address sets a flip-flop that drives the blank/convert line high. The converter answers by raising data-ready about 1.5 µs later, and that rising edge clears the flip-flop. Blank/convert then falls, which starts the conversion. When the converter pulls data-ready low again, the result is valid. It stays valid for as long as the line is left low, so no result register is needed in the glue.

The processor reads the 10-bit result as two bytes from two decoded addresses. It learns that a conversion has finished by reading a third, status address. By default the bytes are packed with the most significant bits at the top. A parameter selects packing toward the low end instead. Reads of any other address leave the bus undriven. Every bus input is sampled on the system clock. Data-ready is brought in through a synchronizer before it is used, and all outputs come straight from registers.

Top module: `conv_bus_bridge`

## Requirements
- R1: While reset is high and on the first clock after it, the blank/convert output is 0, the bus output enable is 0 and the bus data is 0.
- R2: In the first cycle that the write strobe is sampled low with the start address (default 0x40) on the bus, blank/convert goes high at the next clock edge. A strobe held low for many cycles launches only once.
- R3: A write strobe to any address other than the start address leaves blank/convert unchanged.
- R4: A rising edge of data-ready (after a synchronizer of SYNC_STAGES flops, default 2) clears blank/convert at the clock edge after the edge is seen at the last synchronizer stage. If a start strobe lands in that same cycle, the clear takes priority.
- R5: A start strobe issued while blank/convert is already high has no effect. Blank/convert stays high until the data-ready edge.
- R6: With packing to the top (RIGHT_JUST=0), a read of the high address (default 0x41) returns result bits 9..2.
- R7: With packing to the top, a read of the low address (default 0x42) returns result bits 1..0 in byte bits 7..6, with zeros below them.
- R8: With RIGHT_JUST=1, the high address returns result bits 9..8 in byte bits 1..0 with zeros above them, and the low address returns result bits 7..0.
- R9: A read of the status address (default 0x43) returns 1 in bit 0 when the synchronized data-ready is low (result valid) and 0 when it is high. Bits 7..1 are always 0.
- R10: The bus output enable is 1 only after a cycle in which the read strobe was low and the address was one of the three readable addresses. Otherwise the enable is 0 and the data is 0.
- R11: Read data and the enable appear one clock after the cycle in which the read strobe and address are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Processor address |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_dout | output | BUS_W | Read data toward the bus |
| bus_doe | output | 1 | Drive enable for bus_dout; 0 means tri-stated |
| cnv_blank | output | 1 | Blank/convert line to the converter |
| cnv_done_n | input | 1 | Converter data-ready, low when the result is valid |
| cnv_result | input | RES_W | Converter result lines |

## Verification
The bench attacks the double-launch hazard in two ways. It holds the write strobe low long past a full conversion, and it fires a second start during the blanking interval. A design that relaunched on the strobe level, or that re-set the flip-flop mid-pulse, would show a second blank pulse or a blank line that never falls. It runs extreme and alternating result patterns through two instances built with opposite packing, so a swapped byte or a shifted pair of bits shows up in the read data. It also checks that status drops after each launch before it rises again, that strobes to foreign addresses leave blank/convert low, and that unmapped reads keep the enable off.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;

  // Which readable port a bus address selects
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_HI   = 2'd1,
    RSEL_LO   = 2'd2,
    RSEL_STAT = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/cbi_decode.sv
module cbi_decode
  import conv_bus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] HI_ADDR    = 8'h41,
  parameter logic [ADDR_W-1:0] LO_ADDR    = 8'h42,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h43
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              start_hit,
  output rd_sel_e           rd_sel
);

  always_comb begin
    start_hit = (addr == START_ADDR);
    if (addr == HI_ADDR)        rd_sel = RSEL_HI;
    else if (addr == LO_ADDR)   rd_sel = RSEL_LO;
    else if (addr == STAT_ADDR) rd_sel = RSEL_STAT;
    else                        rd_sel = RSEL_NONE;
  end

endmodule

// File: rtl/cbi_start_ctrl.sv
module cbi_start_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_hit,
  input  logic wr_n,
  input  logic done_n,
  output logic blank_o,
  output logic ready_o,
  output logic rise_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic                   wr_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   blank_q;
  logic                   launch;

  // Strobe edge: first sampled low cycle only
  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  // Data-ready synchronizer, idles in the blanked level
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b1;
        else     sync_q[0] <= done_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b1;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign launch = start_hit & ~wr_n & wr_q;

  // Start flip-flop: set by the strobe, cleared by data-ready rising
  always_ff @(posedge clk) begin
    if (rst)         blank_q <= 1'b0;
    else if (rise_o) blank_q <= 1'b0;
    else if (launch) blank_q <= 1'b1;
  end

  assign blank_o = blank_q;
  assign ready_o = ~sync_q[LAST];

endmodule

// File: rtl/cbi_read_port.sv
module cbi_read_port
  import conv_bus_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int BUS_W      = 8,
  parameter bit RIGHT_JUST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  rd_sel_e          rd_sel,
  input  logic             rd_n,
  input  logic             ready,
  input  logic [RES_W-1:0] result,
  output logic [BUS_W-1:0] dout,
  output logic             doe
);

  localparam int LO_W = RES_W - BUS_W;
  localparam int PAD  = BUS_W - LO_W;

  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;
  logic [BUS_W-1:0] stat_byte;
  logic [BUS_W-1:0] mux_byte;

  if (RIGHT_JUST) begin : g_right
    assign hi_byte = {{PAD{1'b0}}, result[RES_W-1:BUS_W]};
    assign lo_byte = result[BUS_W-1:0];
  end else begin : g_left
    assign hi_byte = result[RES_W-1 -: BUS_W];
    assign lo_byte = {result[LO_W-1:0], {PAD{1'b0}}};
  end

  assign stat_byte = {{(BUS_W-1){1'b0}}, ready};

  always_comb begin
    unique case (rd_sel)
      RSEL_HI:   mux_byte = hi_byte;
      RSEL_LO:   mux_byte = lo_byte;
      RSEL_STAT: mux_byte = stat_byte;
      default:   mux_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doe  <= 1'b0;
      dout <= '0;
    end else if (!rd_n && rd_sel != RSEL_NONE) begin
      doe  <= 1'b1;
      dout <= mux_byte;
    end else begin
      doe  <= 1'b0;
      dout <= '0;
    end
  end

endmodule

// File: rtl/conv_bus_bridge.sv
module conv_bus_bridge
  import conv_bus_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUS_W       = 8,
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter bit RIGHT_JUST  = 1'b0,
  parameter logic [ADDR_W-1:0] START_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] HI_ADDR    = 8'h41,
  parameter logic [ADDR_W-1:0] LO_ADDR    = 8'h42,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_doe,
  output logic              cnv_blank,
  input  logic              cnv_done_n,
  input  logic [RES_W-1:0]  cnv_result
);

  logic    start_hit;
  rd_sel_e rd_sel;
  logic    rdy_sync;
  logic    rdy_rise;

  cbi_decode #(
    .ADDR_W(ADDR_W), .START_ADDR(START_ADDR), .HI_ADDR(HI_ADDR),
    .LO_ADDR(LO_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .addr(bus_addr), .start_hit(start_hit), .rd_sel(rd_sel)
  );

  cbi_start_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk(clk), .rst(rst), .start_hit(start_hit), .wr_n(bus_wr_n),
    .done_n(cnv_done_n), .blank_o(cnv_blank), .ready_o(rdy_sync),
    .rise_o(rdy_rise)
  );

  cbi_read_port #(
    .RES_W(RES_W), .BUS_W(BUS_W), .RIGHT_JUST(RIGHT_JUST)
  ) u_read (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_n(bus_rd_n),
    .ready(rdy_sync), .result(cnv_result), .dout(bus_dout), .doe(bus_doe)
  );

endmodule

// File: rtl/conv_bus_bridge_chk.sv
module conv_bus_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h43
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_n,
  input logic              bus_rd_n,
  input logic [BUS_W-1:0]  bus_dout,
  input logic              bus_doe,
  input logic              cnv_blank,
  input logic              rdy_rise
);

  // R2: a fresh start strobe raises blank/convert unless a clear lands
  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_wr_n) && bus_addr == START_ADDR && !rdy_rise) |=> cnv_blank);

  // R3: no start address, no rise of blank/convert
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    (!cnv_blank && (bus_wr_n || bus_addr != START_ADDR)) |=> !cnv_blank);

  // R4: the data-ready edge clears the flop
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (cnv_blank && rdy_rise) |=> !cnv_blank);

  // R5: the pulse holds until the data-ready edge
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cnv_blank && !rdy_rise) |=> cnv_blank);

  // R10: no read strobe, no drive
  p_no_drive_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd_n |=> !bus_doe);

  // R10: an undriven bus carries zeros
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_doe |-> bus_dout == '0);

  // R9: status upper bits are zero
  p_stat_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n && bus_addr == STAT_ADDR) |=> bus_dout[BUS_W-1:1] == '0);

endmodule

bind conv_bus_bridge conv_bus_bridge_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .START_ADDR(START_ADDR), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_n(bus_wr_n),
  .bus_rd_n(bus_rd_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
  .cnv_blank(cnv_blank), .rdy_rise(rdy_rise)
);

// File: tb/conv_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module conv_bus_bridge_tb_top;

  localparam int BLK_D  = 20;
  localparam int CONV_D = 40;
  localparam logic [7:0] A_START = 8'h40, A_HI = 8'h41, A_LO = 8'h42, A_STAT = 8'h43;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr_n = 1'b1;
  logic       bus_rd_n = 1'b1;
  logic [7:0] dout_l, dout_r;
  logic       doe_l, doe_r, blank_l, blank_r;
  logic       cnv_done_n = 1'b0;
  logic [9:0] cnv_result = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  conv_bus_bridge dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_dout(dout_l), .bus_doe(doe_l),
    .cnv_blank(blank_l), .cnv_done_n(cnv_done_n), .cnv_result(cnv_result)
  );

  conv_bus_bridge #(.RIGHT_JUST(1'b1)) dut_r (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_dout(dout_r), .bus_doe(doe_r),
    .cnv_blank(blank_r), .cnv_done_n(cnv_done_n), .cnv_result(cnv_result)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural converter: 0 idle-valid, 1 blanking, 2 blanked, 3 converting
  int         cstate = 0;
  int         ccnt = 0;
  logic [9:0] vin = '0;
  int         launches = 0;
  always @(negedge clk) begin
    if (rst) begin
      cstate = 0; cnv_done_n <= 1'b0;
    end else begin
      case (cstate)
        0: if (blank_l) begin cstate = 1; ccnt = BLK_D; launches++; end
        1: begin
          ccnt--;
          if (ccnt == 0) begin cstate = 2; cnv_done_n <= 1'b1; cnv_result <= '0; end
        end
        2: if (!blank_l) begin cstate = 3; ccnt = CONV_D; end
        3: begin
          if (blank_l) cstate = 2;
          else begin
            ccnt--;
            if (ccnt == 0) begin cstate = 0; cnv_done_n <= 1'b0; cnv_result <= vin; end
          end
        end
        default: cstate = 0;
      endcase
    end
  end

  // Cycle reference model of the bridge
  int         q_done[$];
  bit         m_wr_prev = 1, m_blank = 0, m_oe = 0, m_prev = 1;
  logic [7:0] m_dl = 0, m_dr = 0;
  always @(posedge clk) begin
    if (rst) begin
      q_done = '{1, 1};
      m_wr_prev = 1; m_prev = 1; m_blank = 0; m_oe = 0; m_dl = 0; m_dr = 0;
    end else begin
      bit rise, launch, ready;
      int sel;
      rise   = (q_done[1] == 1) && !m_prev;
      ready  = (q_done[1] == 0);
      launch = !bus_wr_n && m_wr_prev && bus_addr == A_START;
      if (rise) m_blank = 0;
      else if (launch) m_blank = 1;
      sel = (bus_addr == A_HI) ? 1 : (bus_addr == A_LO) ? 2 : (bus_addr == A_STAT) ? 3 : 0;
      m_oe = !bus_rd_n && sel != 0;
      if (!m_oe) begin m_dl = 0; m_dr = 0; end
      else if (sel == 1) begin m_dl = cnv_result[9:2]; m_dr = {6'b0, cnv_result[9:8]}; end
      else if (sel == 2) begin m_dl = {cnv_result[1:0], 6'b0}; m_dr = cnv_result[7:0]; end
      else begin m_dl = {7'b0, ready}; m_dr = {7'b0, ready}; end
      m_prev = (q_done[1] == 1);
      m_wr_prev = bus_wr_n;
      void'(q_done.pop_back());
      q_done.push_front(int'(cnv_done_n));
    end
  end

  // Per-cycle comparison away from the edge
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      check(blank_l == m_blank, "R2 R3 R4 R5 blank", blank_l, m_blank);
      check(blank_r == m_blank, "R2 R4 blank right-packed", blank_r, m_blank);
      check(doe_l == m_oe && doe_r == m_oe, "R10 R11 enable", doe_l, m_oe);
      check(dout_l == m_dl, "R6 R7 R9 R11 data", dout_l, m_dl);
      check(dout_r == m_dr, "R8 R9 data right-packed", dout_r, m_dr);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input int hold);
    @(negedge clk); bus_addr = a; bus_wr_n = 1'b0;
    cycles(hold);
    bus_wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] dl, output logic [7:0] dr, output logic oe);
    @(negedge clk); bus_addr = a; bus_rd_n = 1'b0;
    @(posedge clk); #1;
    dl = dout_l; dr = dout_r; oe = doe_l;
    @(negedge clk); bus_rd_n = 1'b1;
  endtask

  task automatic poll(input logic want, output bit ok);
    logic [7:0] dl, dr; logic oe;
    ok = 0;
    for (int k = 0; k < 400; k++) begin
      bus_read(A_STAT, dl, dr, oe);
      if (dl[0] == want) begin ok = 1; break; end
    end
  endtask

  task automatic one_conversion(input logic [9:0] v, input int hold);
    logic [7:0] dl, dr; logic oe; bit ok;
    int l0;
    vin = v;
    l0 = launches;
    bus_write(A_START, hold);
    cycles(2);
    if (hold < BLK_D) begin
      check(blank_l == 1'b1, "R2 blank high after start", blank_l, 1);
      bus_write(A_START, 1);
      cycles(2);
      check(blank_l == 1'b1, "R5 restart ignored while high", blank_l, 1);
    end
    poll(1'b0, ok);
    check(ok || hold >= BLK_D, "R9 status drops after launch", ok, 1);
    poll(1'b1, ok);
    check(ok, "R9 status reports done", ok, 1);
    check(blank_l == 1'b0, "R4 blank low after data-ready edge", blank_l, 0);
    check(launches == l0 + 1, "R2 R5 exactly one launch", launches - l0, 1);
    bus_read(A_HI, dl, dr, oe);
    check(oe == 1'b1, "R10 enable on high read", oe, 1);
    check(dl == v[9:2], "R6 high byte", dl, v[9:2]);
    check(dr == {6'b0, v[9:8]}, "R8 high byte right-packed", dr, {6'b0, v[9:8]});
    bus_read(A_LO, dl, dr, oe);
    check(dl == {v[1:0], 6'b0}, "R7 low byte", dl, {v[1:0], 6'b0});
    check(dr == v[7:0], "R8 low byte right-packed", dr, v[7:0]);
    bus_read(A_STAT, dl, dr, oe);
    check(dl == 8'h01, "R9 status byte", dl, 8'h01);
  endtask

  initial begin : main_flow
    logic [7:0] dl, dr; logic oe;
    fork
      begin : run
        cycles(4);
        #1;
        check(blank_l == 0 && doe_l == 0 && dout_l == 0, "R1 reset state", {blank_l, doe_l, dout_l}, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(blank_l == 0 && doe_l == 0 && dout_l == 0, "R1 first cycle out of reset", {blank_l, doe_l, dout_l}, 0);
        bus_write(8'h44, 3);
        bus_write(A_HI, 2);
        cycles(3);
        check(blank_l == 1'b0, "R3 foreign write ignored", blank_l, 0);
        bus_read(8'h7F, dl, dr, oe);
        check(oe == 1'b0 && dl == 0, "R10 unmapped read undriven", oe, 0);
        one_conversion(10'h000, 1);
        one_conversion(10'h3FF, 4);
        one_conversion(10'h2A5, 2);
        one_conversion(10'h15A, 1);
        // Strobe held through a whole conversion: still a single launch (R2)
        one_conversion(10'h201, BLK_D + CONV_D + 30);
        one_conversion(10'h0C3, 1);
        bus_read(A_START, dl, dr, oe);
        check(oe == 1'b0, "R10 start address not readable", oe, 0);
        cycles(5);
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule